// File: doc/BRIEF.md
# Three-Channel Center-Aligned PWM with Quarter-Step Resolution

This block turns three 10-bit magnitude words into three center-aligned pulse trains. One shared 8-bit triangle count climbs from 0 to 255 and falls back to 0 without pausing, advancing once per system clock. For each channel, the upper eight bits of its word are compared with that count. The two lower bits then lengthen the pulse in half-system-clock steps. The result is 10-bit duty resolution from an 8-bit counter.

The block runs on a single clock, `clk_2x`, at twice the system rate. One system clock is two `clk_2x` cycles: an early half and a late half. The count moves on after each late half, so one triangle period lasts 510 system clocks, or 1020 `clk_2x` cycles. Software-side logic writes new words with a load strobe. The words wait in holding registers and move into the active registers only at the end of a period. A one-cycle marker flags the first `clk_2x` cycle of every period.

Top module: `pwm3_center_top`

## Requirements
- R1: The `period_start` marker pulses exactly once every 1020 `clk_2x` cycles.
- R2: `period_start` is high for one `clk_2x` cycle per period.
- R3: Take a word with upper part r = word[9:2] and lower part l = word[1:0]. Its output is high for min(4r+2+l, 1020) `clk_2x` cycles of each period.
- R4: Position p counts from 0 at the cycle `period_start` is high. Let lead = l/2 (integer division) and trail = l − lead. The output is high exactly when p < 2r+2+trail or p ≥ 1020−2r−lead. The pulse is therefore centred on the period boundary. The extra half steps go first to the trailing edge, then to the leading edge.
- R5: A load changes nothing in the period in which it occurs. The word captured by the most recent load in a period takes effect from the next `period_start`, and any earlier load in that period is discarded.
- R6: An upper part of 255 holds the output high for the whole period, whatever the two lower bits are.
- R7: A word of 0 gives a pulse two `clk_2x` cycles wide, at positions 0 and 1.
- R8: Each channel's output depends only on its own word. Word slices are ch0 = `word_in[9:0]`, ch1 = `word_in[19:10]` and ch2 = `word_in[29:20]`.
- R9: While `rst_n` is low, all outputs are low. After release, all active words start at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Clock at twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures `word_in` into the holding registers |
| word_in | input | 30 | Three packed 10-bit magnitude words |
| pwm_out | output | 3 | Center-aligned PWM, one bit per channel |
| period_start | output | 1 | One-cycle marker at position 0 of each period |

## Verification
On every cycle, the in-RTL properties check the following. The count moves by exactly one step per system clock and holds in between. Markers are one cycle wide and exactly a period apart. Active words change only at the end-of-period transfer and take the held value there. A full upper part forces the output high. Other behaviour can only be shown by the bench's scenarios: the exact pulse shape position by position, the split of half steps between the two edges, the last-load-wins rule within a period, and the clamp near full scale at upper part 254. These scenarios compare whole periods against a model of the requirements.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

   // Edge extension selects derived from the two fractional bits
   typedef struct packed {
      logic lead;      // one half step ahead of the rising edge
      logic trail_lo;  // one half step after the falling edge
      logic trail_hi;  // a second half step after the falling edge
   } ext_t;

   function automatic ext_t ext_split(input logic [1:0] low);
      ext_t e;
      e.lead     = low[1];
      e.trail_lo = |low;
      e.trail_hi = &low;
      return e;
   endfunction

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
   import pwm3_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_2x,
   input  logic             rst_n,
   output logic             late_half,
   output logic [CNT_W-1:0] cnt_now,
   output logic [CNT_W-1:0] cnt_prev,
   output logic [CNT_W-1:0] cnt_next,
   output logic             swap_en,
   output logic             period_start
);

   localparam logic [CNT_W-1:0] TOP    = '1;
   localparam logic [CNT_W-1:0] BOT    = '0;
   localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] TOP_M1 = TOP - ONE;
   localparam int unsigned      HALF_PER = 4 * ((1 << CNT_W) - 1);
   localparam int unsigned      GAP_W    = $clog2(HALF_PER + 1);
   localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(HALF_PER - 1);

   if (CNT_W < 2) begin : g_bad_width
      $error("pwm3_timebase: CNT_W must be at least 2");
   end

   dir_e             dir_q;
   logic [CNT_W-1:0] cnt_q;
   logic             half_q;

   always_comb begin
      if (dir_q == DIR_UP) begin
         cnt_next = (cnt_q == TOP) ? TOP_M1 : cnt_q + ONE;
         cnt_prev = (cnt_q == BOT) ? ONE    : cnt_q - ONE;
      end else begin
         cnt_next = (cnt_q == BOT) ? ONE    : cnt_q - ONE;
         cnt_prev = (cnt_q == TOP) ? TOP_M1 : cnt_q + ONE;
      end
   end

   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         half_q       <= 1'b0;
         cnt_q        <= BOT;
         dir_q        <= DIR_UP;
         period_start <= 1'b0;
      end else begin
         half_q       <= ~half_q;
         period_start <= (cnt_q == BOT) && !half_q;
         if (half_q) begin
            cnt_q <= cnt_next;
            if (dir_q == DIR_UP && cnt_q == TOP) begin
               dir_q <= DIR_DOWN;
            end else if (dir_q == DIR_DOWN && cnt_q == BOT) begin
               dir_q <= DIR_UP;
            end
         end
      end
   end

   assign late_half = half_q;
   assign cnt_now   = cnt_q;
   assign swap_en   = half_q && (dir_q == DIR_DOWN) && (cnt_q == ONE);

   // Support counter for the marker spacing check
   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (period_start) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + GAP_W'(1);
      end
   end

   // R1
   cnt_step_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      half_q |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));

   // R1
   cnt_hold_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      !half_q |=> $stable(cnt_q));

   // R1
   marker_gap_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      (period_start && seen_q) |-> (gap_q == GAP_END));

   // R2
   marker_width_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      period_start |=> !period_start);

endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel
   import pwm3_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned FRAC_W = 2,
   localparam int unsigned WORD_W = CNT_W + FRAC_W
) (
   input  logic              clk_2x,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              late_half,
   input  logic [CNT_W-1:0]  cnt_now,
   input  logic [CNT_W-1:0]  cnt_prev,
   input  logic [CNT_W-1:0]  cnt_next,
   input  logic              swap_en,
   output logic              pwm_q
);

   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] act_q;
   logic [CNT_W-1:0]  act_top;
   ext_t              ext;
   logic              hit_now, hit_prev, hit_next;
   logic              pwm_d;

   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         act_q  <= '0;
      end else begin
         if (load) begin
            hold_q <= word_in;
         end
         if (swap_en) begin
            act_q <= hold_q;
         end
      end
   end

   assign act_top = act_q[WORD_W-1 -: CNT_W];

   if (FRAC_W == 2) begin : g_frac
      assign ext = ext_split(act_q[1:0]);
   end else if (FRAC_W == 0) begin : g_nofrac
      assign ext = '0;
   end else begin : g_bad_frac
      $error("pwm3_channel: FRAC_W must be 0 or 2");
      assign ext = '0;
   end

   assign hit_now  = act_top >= cnt_now;
   assign hit_prev = act_top >= cnt_prev;
   assign hit_next = act_top >= cnt_next;

   always_comb begin
      pwm_d = hit_now;
      if (late_half && ext.lead && hit_next) begin
         pwm_d = 1'b1;
      end
      if (((!late_half && ext.trail_lo) || (late_half && ext.trail_hi)) && hit_prev) begin
         pwm_d = 1'b1;
      end
   end

   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= pwm_d;
      end
   end

   // R5
   act_hold_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      !swap_en |=> $stable(act_q));

   // R5
   act_swap_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      swap_en |=> (act_q == $past(hold_q)));

   // R6
   top_full_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      (act_top == '1) |=> pwm_q);

endmodule

// File: rtl/pwm3_center_top.sv
module pwm3_center_top
   import pwm3_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned FRAC_W = 2,
   localparam int unsigned WORD_W = CNT_W + FRAC_W,
   localparam int unsigned BUS_W  = NUM_CH * WORD_W
) (
   input  logic              clk_2x,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BUS_W-1:0]  word_in,
   output logic [NUM_CH-1:0] pwm_out,
   output logic              period_start
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm3_center_top: NUM_CH must be at least 1");
   end

   logic             late_half;
   logic [CNT_W-1:0] cnt_now, cnt_prev, cnt_next;
   logic             swap_en;

   pwm3_timebase #(
      .CNT_W (CNT_W)
   ) i_timebase (
      .clk_2x       (clk_2x),
      .rst_n        (rst_n),
      .late_half    (late_half),
      .cnt_now      (cnt_now),
      .cnt_prev     (cnt_prev),
      .cnt_next     (cnt_next),
      .swap_en      (swap_en),
      .period_start (period_start)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pwm3_channel #(
         .CNT_W  (CNT_W),
         .FRAC_W (FRAC_W)
      ) i_channel (
         .clk_2x    (clk_2x),
         .rst_n     (rst_n),
         .load      (load),
         .word_in   (word_in[ch*WORD_W +: WORD_W]),
         .late_half (late_half),
         .cnt_now   (cnt_now),
         .cnt_prev  (cnt_prev),
         .cnt_next  (cnt_next),
         .swap_en   (swap_en),
         .pwm_q     (pwm_out[ch])
      );
   end

endmodule

// File: tb/test_pwm3_center_top.sv
module test_pwm3_center_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 3;
   localparam int PER        = 1020;
   localparam int NSCEN      = 22;
   localparam int LIMIT      = 60000;

   logic        clk_2x = 1'b0;
   logic        rst_n;
   logic        load;
   logic [29:0] word_in;
   logic [2:0]  pwm_out;
   logic        period_start;

   always #(CLK_PERIOD/2) clk_2x = ~clk_2x;

   pwm3_center_top i_pwm3_center_top (
      .clk_2x       (clk_2x),
      .rst_n        (rst_n),
      .load         (load),
      .word_in      (word_in),
      .pwm_out      (pwm_out),
      .period_start (period_start)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Pulse shape from R4
   function automatic bit exp_bit(input logic [9:0] w, input int p);
      int r, l, ld, tr;
      r  = int'(w[9:2]);
      l  = int'(w[1:0]);
      ld = l / 2;
      tr = l - ld;
      return (p < 2*r + 2 + tr) || (p >= PER - 2*r - ld);
   endfunction

   // High time from R3
   function automatic int exp_high(input logic [9:0] w);
      int v;
      v = 4*int'(w[9:2]) + 2 + int'(w[1:0]);
      return (v > PER) ? PER : v;
   endfunction

   logic [29:0] scen [NSCEN];

   initial begin
      logic [29:0] pending;
      logic [29:0] cur;
      int  p, mk, sidx, done_per, cycles;
      int  mism [NCH];
      int  hi   [NCH];
      int  first_bad [NCH];
      bit  started, loaded_here, fin;

      void'($urandom(32'h00C0FFEE));
      scen[0] = {10'd0,    10'd0,    10'd0};     // R7
      scen[1] = {10'd1023, 10'd1020, 10'd3};     // R6 clamp
      scen[2] = {10'd1019, 10'd1018, 10'd1017};  // near full scale
      scen[3] = {10'd3,    10'd2,    10'd1};     // quarter steps
      scen[4] = {10'd514,  10'd513,  10'd512};
      scen[5] = {10'd0,    10'd1023, 10'd0};     // R8
      for (int i = 6; i < NSCEN; i++) begin
         scen[i] = {10'($urandom), 10'($urandom), 10'($urandom)};
      end

      rst_n   = 1'b0;
      load    = 1'b0;
      word_in = '0;
      repeat (4) @(negedge clk_2x);
      // R9: reset state
      chk(pwm_out == 3'b000, "R9", "pwm_out in reset", int'(pwm_out), 0);
      chk(period_start == 1'b0, "R9", "marker in reset", int'(period_start), 0);
      rst_n = 1'b1;

      pending = '0; cur = '0;
      p = 0; mk = 0; sidx = 0; done_per = 0; cycles = 0;
      started = 1'b0; loaded_here = 1'b0; fin = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         mism[c] = 0; hi[c] = 0; first_bad[c] = -1;
      end

      while (!fin) begin
         @(negedge clk_2x);
         cycles++;
         load = 1'b0;
         if (cycles > LIMIT) begin
            chk(1'b0, "R1", "watchdog expired", cycles, LIMIT);
            fin = 1'b1;
         end else begin
            if (period_start) begin
               if (started) begin
                  chk(p == PER, "R1", "period length", p, PER);
                  chk(mk == 1, "R2", "marker cycles per period", mk, 1);
                  for (int c = 0; c < NCH; c++) begin
                     logic [9:0] w;
                     w = cur[c*10 +: 10];
                     chk(mism[c] == 0, loaded_here ? "R5" : "R4",
                         $sformatf("ch%0d word %0d shape mismatches (first at p=%0d)",
                                   c, w, first_bad[c]), mism[c], 0);
                     chk(hi[c] == exp_high(w),
                         (w[9:2] == 8'hFF) ? "R6" : ((w == 10'd0) ? "R7" : "R3"),
                         $sformatf("ch%0d word %0d high cycles", c, w),
                         hi[c], exp_high(w));
                  end
                  if (cur[9:0] != cur[19:10] && cur[19:10] != cur[29:20]
                      && cur[9:0] != cur[29:20]) begin
                     chk(mism[0] + mism[1] + mism[2] == 0, "R8",
                         "independent channels total mismatches",
                         mism[0] + mism[1] + mism[2], 0);
                  end
                  done_per++;
                  if (done_per == NSCEN + 1) fin = 1'b1;
               end
               started     = 1'b1;
               cur         = pending;
               p           = 0;
               mk          = 0;
               loaded_here = 1'b0;
               for (int c = 0; c < NCH; c++) begin
                  mism[c] = 0; hi[c] = 0; first_bad[c] = -1;
               end
            end
            if (started && !fin) begin
               if (period_start) mk++;
               for (int c = 0; c < NCH; c++) begin
                  if (pwm_out[c]) hi[c]++;
                  if (pwm_out[c] != exp_bit(cur[c*10 +: 10], p)) begin
                     if (first_bad[c] < 0) first_bad[c] = p;
                     mism[c]++;
                  end
               end
               p++;
               // R5: a decoy load followed by the real one in the same period
               if (sidx < NSCEN && p == 7 && sidx[0]) begin
                  load    = 1'b1;
                  word_in = ~scen[sidx];
                  pending = word_in;
                  loaded_here = 1'b1;
               end
               if (sidx < NSCEN && p == 300) begin
                  load    = 1'b1;
                  word_in = scen[sidx];
                  pending = word_in;
                  loaded_here = 1'b1;
                  sidx++;
               end
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule